// File: doc/BRIEF.md
# Saturating Rounding Element Shifter

This block shifts one integer element by a signed amount that comes from a second operand. The sign of the count picks the direction: positive counts shift left, negative counts shift right by their magnitude, and a count of zero passes the element through. The element can be 8, 16, 32 or 64 bits wide. Operands are treated as signed or unsigned. Right shifts can round to nearest by adding half of the dropped weight first. Left shifts can saturate, so that the result is clamped to the element's range instead of losing high bits.

The shifted result is combinational. A sticky saturation flag is registered. It records any valid operation that had to clamp, and it stays set until a clear input is pulsed. Bits of the value input above the selected element width are ignored. The result is placed on a 64-bit bus, sign-extended for signed operations and zero-extended for unsigned ones.

Top module: `sat_rnd_shifter`

## Requirements
- R1: The element width is 8 << size_i (size code 0..3 gives 8, 16, 32 or 64 bits). Bits of value_i above the element width are ignored. Bits of result_o above the element width repeat the result's top bit when signed_i=1 and are zero when signed_i=0.
- R2: The shift count is shift_i[7:0] read as a two's complement byte, and shift_i[63:8] has no effect. A count of zero returns the element unchanged, with its extension as in R1.
- R3: A non-saturating left shift keeps the low element bits of the shifted value. A left count at or above the element width gives 0.
- R4: A saturating left shift whose count is at or above the element width gives 0 for a zero element. For a nonzero element it gives the signed maximum or minimum (following the element's sign) when signed_i=1, or all ones when signed_i=0, and it counts as a saturation.
- R5: A saturating left shift whose count is below the width returns the exact product when it fits the element's signed or unsigned range. Otherwise it returns the nearest range bound and counts as a saturation.
- R6: A non-rounding right shift by n is arithmetic for signed and logical for unsigned. When n is at or above the width, it gives -1 for a negative signed element and 0 in every other case.
- R7: A rounding right shift by n below the width returns floor((x + 2^(n-1)) / 2^n) computed without overflow. For a 64-bit unsigned element, a carry out of the addition therefore appears as a 1 at result bit 64-n.
- R8: A rounding right shift by n at or above the width gives 0. The one exception is an unsigned 64-bit element shifted by exactly 64, which gives the carry out of x + 2^63 (0 or 1).
- R9: sat_flag_o is 0 after reset. It is set one clock after a cycle with valid_i=1 whose operation saturates, holds until flag_clr_i is sampled high, and is cleared by flag_clr_i. When a set and a clear occur in the same cycle, the set wins.
- R10: round_i has no effect on left shifts, and sat_i has no effect on right shifts. Operations with valid_i=0 never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation is real; qualifies flag setting |
| value_i | input | 64 | Element to shift (low bits used) |
| shift_i | input | 64 | Shift operand; low byte is the signed count |
| size_i | input | 2 | Element width code |
| signed_i | input | 1 | 1 = signed operands |
| round_i | input | 1 | 1 = rounding on right shifts |
| sat_i | input | 1 | 1 = saturating left shifts |
| flag_clr_i | input | 1 | Clears the sticky saturation flag |
| result_o | output | 64 | Shifted element, extended to 64 bits |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The only internal state is the sticky flag. A flag that is wrongly set, lost or not cleared shows on sat_flag_o one clock after the operation or clear that should have changed it. The bench compares the flag after every operation, so a fault surfaces within one cycle. Everything else is combinational. A wrong range bound, rounding constant or width decode shows on result_o in the same cycle for the affected size and mode. For that reason, the random mix biases the counts toward values just around each element width, and directed cases hit the 64-bit rounding carry.

// File: rtl/sat_rnd_shifter.sv
module sat_rnd_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [63:0] value_i,
  input  logic [63:0] shift_i,
  input  logic [1:0]  size_i,
  input  logic        signed_i,
  input  logic        round_i,
  input  logic        sat_i,
  input  logic        flag_clr_i,
  output logic [63:0] result_o,
  output logic        sat_flag_o
);

  logic [7:0]   esz;
  logic [5:0]   top;
  logic [63:0]  emask, elem, ext;
  logic         msb;
  logic [127:0] wide;
  logic [6:0]   lamt;
  logic [7:0]   ramt;
  logic         is_left, is_right, big_l, big_r, keep_carry;
  logic [127:0] shl, smax, smin, umax, rbias, sum, rsh;
  logic         over;
  logic         sat_hit;
  logic [63:0]  raw, r_el;
  logic         r_sign;

  assign esz   = 8'd8 << size_i;
  assign top   = 6'(esz - 8'd1);
  assign emask = (size_i == 2'd3) ? '1 : ((64'd1 << esz) - 64'd1);
  assign elem  = value_i & emask;
  assign msb   = signed_i & elem[top];
  assign ext   = elem | ({64{msb}} & ~emask);
  assign wide  = {{64{msb}}, ext};

  assign lamt     = shift_i[6:0];
  assign ramt     = 8'(-shift_i[7:0]);
  assign is_right = shift_i[7];
  assign is_left  = !shift_i[7] && (shift_i[6:0] != 7'd0);
  assign big_l    = {1'b0, lamt} >= esz;
  assign big_r    = ramt >= esz;

  assign shl  = wide << lamt;
  assign smax = (128'd1 << top) - 128'd1;
  assign smin = ~smax;
  assign umax = {64'd0, emask};
  assign over = signed_i ? (($signed(shl) > $signed(smax)) || ($signed(shl) < $signed(smin)))
                         : (shl > umax);

  assign rbias = round_i ? (128'd1 << (ramt - 8'd1)) : 128'd0;
  assign sum   = wide + rbias;
  assign rsh   = signed_i ? 128'($signed(sum) >>> ramt) : (sum >> ramt);
  assign keep_carry = !signed_i && (size_i == 2'd3) && (ramt == 8'd64);

  always_comb begin
    sat_hit = 1'b0;
    raw     = ext;
    if (is_left) begin
      if (sat_i) begin
        if (big_l) begin
          if (elem != 64'd0) begin
            sat_hit = 1'b1;
            raw = signed_i ? (msb ? smin[63:0] : smax[63:0]) : emask;
          end else begin
            raw = 64'd0;
          end
        end else if (over) begin
          sat_hit = 1'b1;
          raw = signed_i ? (shl[127] ? smin[63:0] : smax[63:0]) : emask;
        end else begin
          raw = shl[63:0];
        end
      end else begin
        raw = big_l ? 64'd0 : shl[63:0];
      end
    end else if (is_right) begin
      raw = (round_i && big_r && !keep_carry) ? 64'd0 : rsh[63:0];
    end
  end

  assign r_el     = raw & emask;
  assign r_sign   = signed_i & r_el[top];
  assign result_o = r_el | ({64{r_sign}} & ~emask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sat_flag_o <= 1'b0;
    else if (valid_i && sat_hit) sat_flag_o <= 1'b1;
    else if (flag_clr_i)         sat_flag_o <= 1'b0;
  end

  p_narrow_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!signed_i && size_i != 2'd3) |-> ((result_o & ~emask) == 64'd0));

  p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i[7:0] == 8'd0 && size_i == 2'd3) |-> (result_o == value_i));

  p_left_wide_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_i && !shift_i[7] && shift_i[6:0] >= 7'd64) |-> (result_o == 64'd0));

  p_usat_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !signed_i) |-> (result_o == emask));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sat_hit) |=> sat_flag_o);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag_o && !flag_clr_i) |=> sat_flag_o);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !(valid_i && sat_hit)) |=> !sat_flag_o);

endmodule

// File: tb/sat_rnd_shifter_tb.sv
module sat_rnd_shifter_tb_top;
  logic clk = 0, rst_n = 0;
  logic valid_i = 0, signed_i = 0, round_i = 0, sat_i = 0, flag_clr_i = 0;
  logic [63:0] value_i = 0, shift_i = 0;
  logic [1:0] size_i = 0;
  logic [63:0] result_o;
  logic sat_flag_o;
  int checks = 0, errors = 0;
  logic exp_flag = 0;
  logic done = 0;

  always #4 clk = ~clk;

  sat_rnd_shifter dut_i (.clk, .rst_n, .valid_i, .value_i, .shift_i, .size_i,
    .signed_i, .round_i, .sat_i, .flag_clr_i, .result_o, .sat_flag_o);

  function automatic logic [64:0] model(logic [63:0] v, logic [63:0] sh, logic [1:0] sz,
                                        logic sg, logic rd, logic st);
    int e, s, n;
    logic [63:0] mask, x, res;
    logic neg, sat;
    logic signed [127:0] p, mx, mn;
    logic [64:0] s65;
    e = 8 << sz;
    mask = (e == 64) ? {64{1'b1}} : ((64'd1 << e) - 1);
    x = v & mask;
    neg = sg && x[e-1];
    if (neg) x = x | ~mask;
    s = int'($signed(sh[7:0]));
    sat = 0;
    res = x;
    if (s > 0) begin
      if (s >= e) begin
        if (st && x != 0) begin
          sat = 1;
          res = sg ? (neg ? ~((64'd1 << (e-1)) - 1) : (64'd1 << (e-1)) - 1) : mask;
        end else res = 0;
      end else begin
        p = sg ? $signed({{64{x[63]}}, x}) : $signed({64'd0, x});
        p = p <<< s;
        mx = sg ? (128'sd1 <<< (e-1)) - 1 : (128'sd1 <<< e) - 1;
        mn = sg ? -(128'sd1 <<< (e-1)) : 128'sd0;
        if (st && p > mx) begin sat = 1; res = mx[63:0]; end
        else if (st && p < mn) begin sat = 1; res = mn[63:0]; end
        else res = p[63:0];
      end
    end else if (s < 0) begin
      n = -s;
      if (!rd) begin
        if (n >= e) res = neg ? {64{1'b1}} : 64'd0;
        else res = sg ? 64'($signed(x) >>> n) : x >> n;
      end else if (n >= e) begin
        s65 = {1'b0, x} + {1'b0, 64'h8000_0000_0000_0000};
        res = (!sg && e == 64 && n == 64) ? {63'd0, s65[64]} : 64'd0;
      end else begin
        s65 = {sg & x[63], x} + (65'd1 << (n-1));
        res = sg ? 64'($signed(s65) >>> n) : 64'(s65 >> n);
      end
    end
    res = res & mask;
    if (sg && res[e-1]) res = res | ~mask;
    return {sat, res};
  endfunction

  function automatic string tag_of(logic [63:0] sh, logic [1:0] sz, logic rd, logic st);
    int e, s;
    e = 8 << sz;
    s = int'($signed(sh[7:0]));
    if (s == 0) return "R2";
    if (s > 0) return !st ? "R3" : (s >= e ? "R4" : "R5");
    if (!rd) return "R6";
    return (-s >= e) ? "R8" : "R7";
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(logic [63:0] v, logic [63:0] sh, logic [1:0] sz, logic sg, logic rd,
                    logic st, logic vld, logic clr, string tag);
    logic [64:0] m;
    @(negedge clk);
    value_i = v; shift_i = sh; size_i = sz; signed_i = sg; round_i = rd; sat_i = st;
    valid_i = vld; flag_clr_i = clr;
    m = model(v, sh, sz, sg, rd, st);
    #1;
    chk(tag, result_o, m[63:0]);
    if (vld && m[64]) exp_flag = 1;
    else if (clr) exp_flag = 0;
    @(posedge clk); #1;
    chk("R9", {63'd0, sat_flag_o}, {63'd0, exp_flag});
    valid_i = 0; flag_clr_i = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk("R9", {63'd0, sat_flag_o}, 64'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R9", {63'd0, sat_flag_o}, 64'd0);
    // R1 narrow extension, upper input bits ignored
    op(64'hFFFF_FFFF_FFFF_FF85, 64'd0, 2'd0, 1, 0, 0, 1, 0, "R1");
    op(64'hABCD_0000_0000_8085, 64'd0, 2'd1, 0, 0, 0, 1, 0, "R1");
    // R2 upper shift bits ignored
    op(64'h1234, 64'hFF00_0000_0000_0000, 2'd3, 0, 0, 0, 1, 0, "R2");
    op(64'h0F, 64'h7777_0000_0000_0102, 2'd0, 0, 0, 0, 1, 0, "R2");
    // R3 / R4 / R5
    op(64'h81, 64'd1, 2'd0, 0, 0, 0, 1, 0, "R3");
    op(64'h5, 64'd8, 2'd0, 1, 0, 0, 1, 0, "R3");
    op(64'h40, 64'd1, 2'd0, 1, 0, 1, 1, 0, "R5");
    op(64'h1, 64'd0, 2'd0, 0, 0, 0, 0, 1, "R2");
    op(64'h80, 64'd9, 2'd0, 1, 0, 1, 1, 0, "R4");
    op(64'h0, 64'd100, 2'd3, 1, 0, 1, 0, 1, "R4");
    op(64'h8000_0000_0000_0000, 64'd1, 2'd3, 0, 0, 1, 0, 0, "R5");
    op(64'h7FFF, 64'd0, 2'd1, 1, 0, 0, 0, 1, "R2");
    // R9 set wins over clear
    op(64'hFF, 64'd1, 2'd0, 0, 0, 1, 1, 1, "R5");
    op(64'h0, 64'd0, 2'd0, 0, 0, 0, 0, 1, "R9");
    // R6 / R7 / R8
    op(64'h80, 64'hFF, 2'd0, 1, 0, 0, 1, 0, "R6");
    op(64'h80, 64'h80, 2'd0, 1, 0, 0, 1, 0, "R6");
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 2'd3, 0, 1, 0, 1, 0, "R7");
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFC, 2'd3, 0, 1, 0, 1, 0, "R7");
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'hFF, 2'd3, 1, 1, 0, 1, 0, "R7");
    op(64'h8000_0000_0000_0000, 64'hC0, 2'd3, 0, 1, 0, 1, 0, "R8");
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'hC0, 2'd3, 0, 1, 0, 1, 0, "R8");
    op(64'hFF, 64'hF8, 2'd0, 0, 1, 0, 1, 0, "R8");
    // R10 round ignored left, sat ignored right, invalid never sets
    op(64'h3, 64'd2, 2'd0, 0, 1, 0, 1, 0, "R10");
    op(64'hF0, 64'hFC, 2'd0, 1, 0, 1, 1, 0, "R10");
    op(64'hFF, 64'd4, 2'd0, 0, 0, 1, 0, 0, "R10");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] v, sh;
      logic [1:0] sz;
      logic sg, rd, st, vld, clr;
      int e, d;
      v  = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) v = v >> $urandom_range(0, 63);
      sz = 2'($urandom_range(0, 3));
      e  = 8 << sz;
      d  = $urandom_range(0, 4);
      sh = {$urandom, $urandom};
      if (d == 0) sh[7:0] = 8'($urandom_range(0, 255));
      else begin
        int c;
        c = e + $urandom_range(0, 4) - 2;
        if ($urandom_range(0, 1) == 0) c = $urandom_range(0, e);
        if ($urandom_range(0, 1) == 0) c = -c;
        sh[7:0] = 8'(c);
      end
      sg  = 1'($urandom_range(0, 1));
      rd  = 1'($urandom_range(0, 1));
      st  = 1'($urandom_range(0, 1));
      vld = ($urandom_range(0, 7) != 0);
      clr = ($urandom_range(0, 9) == 0);
      op(v, sh, sz, sg, rd, st, vld, clr, tag_of(sh, sz, rd, st));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule